// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit settles conditional branches while the branch instruction is still in the decode stage of a five-stage pipeline. It owns the fetch program counter and its incrementer. For the instruction in decode it takes the incremented address of that instruction, the two register operands and a 16-bit offset. A dedicated target adder computes the branch destination. A dedicated equality comparator tests the operands. Neither shares hardware with the execute-stage ALU.

When the decoded branch condition holds, the unit selects the target as the next fetch address. In the same cycle it raises a flush so that the instruction already fetched behind the branch becomes a bubble. Otherwise the fetch address moves on by one instruction. A stall freezes the program counter and suppresses any redirect or flush. Branch prediction, register-indirect jumps and operand forwarding into the comparator are handled elsewhere.

Top module: `branch_resolve_unit`

## Requirements
- R1: After rst_ni is released, pc_o equals RESET_PC (default 0).
- R2: With no taken branch and stall_i low, pc_o advances by 4 at each rising clock edge, and pc_plus4_o always equals pc_o + 4.
- R3: target_o equals id_pc_plus4_i plus the 16-bit offset_i sign-extended and shifted left by 2, modulo 2^32. This holds for both positive and negative offsets.
- R4: With br_type_i = 2'b01 (branch if equal), taken_o is high exactly when rs_val_i equals rt_val_i in all 32 bits.
- R5: With br_type_i = 2'b10 (branch if not equal), taken_o is high exactly when rs_val_i differs from rt_val_i in any bit.
- R6: When taken_o is high, pc_o takes the value of target_o at the next rising edge.
- R7: flush_o is high in the same cycle as taken_o and only then.
- R8: While stall_i is high, pc_o keeps its value across the edge, and taken_o and flush_o stay low, even if a branch condition holds.
- R9: br_type_i = 2'b00 (no branch) and 2'b11 (reserved) never produce taken_o, even with equal operands.
- R10: Sequential advance from 0xFFFFFFFC wraps pc_o to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Hold the PC and block any redirect or flush |
| br_type_i | input | 2 | Decoded branch kind: 00 none, 01 equal, 10 not equal, 11 reserved |
| rs_val_i | input | 32 | First source operand read in decode |
| rt_val_i | input | 32 | Second source operand read in decode |
| offset_i | input | 16 | Signed word offset from the branch instruction |
| id_pc_plus4_i | input | 32 | Incremented address of the instruction in decode |
| pc_o | output | 32 | Current fetch address |
| pc_plus4_o | output | 32 | Sequential successor of pc_o |
| target_o | output | 32 | Computed branch target |
| taken_o | output | 1 | Branch condition met and not stalled |
| flush_o | output | 1 | Turn the fetched instruction into a bubble |

## Verification
The vector table pairs both branch kinds with equal and unequal operands. That separates a correct condition from an inverted one or from one that ignores br_type_i. Operands that differ only in bit 31 expose a comparator that drops the top bits. Offsets of +1, -1, the most negative value and the most positive value exercise sign extension and the shift. One target lands on 0xFFFFFFFC, and the sequential step from there checks the wrap. A stalled cycle with a true condition shows that the PC holds and that the flush is suppressed.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_RSVD = 2'b11
  } br_kind_e;
endpackage

// File: rtl/pc_incr.sv
module pc_incr #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] pc_next_o
);
  localparam logic [XLEN-1:0] StepV = XLEN'(STEP);
  assign pc_next_o = pc_i + StepV;
endmodule

// File: rtl/br_target_adder.sv
module br_target_adder #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int SHIFT = 2
) (
  input  logic [XLEN-1:0]  pc_plus_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int ExtW = XLEN - OFF_W - SHIFT;
  logic [XLEN-1:0] off_ext;

  assign off_ext  = {{ExtW{off_i[OFF_W-1]}}, off_i, {SHIFT{1'b0}}};
  assign target_o = pc_plus_i + off_ext;

  // word alignment of the base must survive the add
  always_comb begin
    if (!$isunknown({pc_plus_i, off_i}))
      assert_target_align_R3: assert (target_o[SHIFT-1:0] == pc_plus_i[SHIFT-1:0]);
  end
endmodule

// File: rtl/eq_cmp.sv
module eq_cmp #(
  parameter int XLEN  = 32,
  parameter int CHUNK = 8
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            eq_o
);
  localparam int NChunk = XLEN / CHUNK;
  logic [NChunk-1:0] chunk_eq;

  for (genvar g = 0; g < NChunk; g++) begin : g_chunk
    assign chunk_eq[g] = ~|(a_i[g*CHUNK +: CHUNK] ^ b_i[g*CHUNK +: CHUNK]);
  end

  assign eq_o = &chunk_eq;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import br_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              OFF_W    = 16,
  parameter int              INSTR_B  = 4,
  parameter int              CMP_CHUNK = 8,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic [1:0]       br_type_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]  id_pc_plus4_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  pc_plus4_o,
  output logic [XLEN-1:0]  target_o,
  output logic             taken_o,
  output logic             flush_o
);
  localparam int Shift = $clog2(INSTR_B);

  br_kind_e        kind;
  logic            ops_eq;
  logic            cond;
  logic [XLEN-1:0] pc_q, pc_seq, pc_d;

  assign kind = br_kind_e'(br_type_i);

  pc_incr #(.XLEN(XLEN), .STEP(INSTR_B)) u_incr (
    .pc_i      (pc_q),
    .pc_next_o (pc_seq)
  );

  br_target_adder #(.XLEN(XLEN), .OFF_W(OFF_W), .SHIFT(Shift)) u_tgt (
    .pc_plus_i (id_pc_plus4_i),
    .off_i     (offset_i),
    .target_o  (target_o)
  );

  eq_cmp #(.XLEN(XLEN), .CHUNK(CMP_CHUNK)) u_cmp (
    .a_i  (rs_val_i),
    .b_i  (rt_val_i),
    .eq_o (ops_eq)
  );

  always_comb begin
    unique case (kind)
      BR_EQ:   cond = ops_eq;
      BR_NE:   cond = ~ops_eq;
      default: cond = 1'b0;
    endcase
  end

  assign taken_o = cond & ~stall_i;
  assign flush_o = taken_o;
  assign pc_d    = taken_o ? target_o : pc_seq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= RESET_PC;
    else if (!stall_i) pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign pc_plus4_o = pc_seq;

  assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !taken_o) |=> pc_o == $past(pc_plus4_o));

  assert_redirect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> pc_o == $past(target_o));

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(pc_o));

  assert_stall_noflush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !flush_o);

  assert_kind_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_type_i == 2'b00 || br_type_i == 2'b11) |-> !taken_o);

  assert_eq_sense_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_type_i == 2'b01 && !stall_i && rs_val_i == rt_val_i) |-> taken_o);
endmodule

// File: tb/tb_branch_resolve_unit.sv
module tb_branch_resolve_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic [1:0]  btype;
  logic [31:0] rs, rt, pc4;
  logic [15:0] off;
  logic [31:0] pc, pc_p4, tgt;
  logic        taken, flush;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  branch_resolve_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .br_type_i(btype),
    .rs_val_i(rs), .rt_val_i(rt), .offset_i(off), .id_pc_plus4_i(pc4),
    .pc_o(pc), .pc_plus4_o(pc_p4), .target_o(tgt), .taken_o(taken), .flush_o(flush)
  );

  // type, rs, rt, offset, id_pc_plus4, expected target, expected taken
  typedef struct packed {
    logic [1:0]  ty;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] o;
    logic [31:0] p4;
    logic [31:0] et;
    logic        ek;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 32'd5,        32'd5,        16'h0004, 32'h100,   32'h110,      1'b1}, // R4 equal
    '{2'b01, 32'd5,        32'd6,        16'h0004, 32'h100,   32'h110,      1'b0}, // R4 unequal
    '{2'b10, 32'd5,        32'd6,        16'hFFFF, 32'h200,   32'h1FC,      1'b1}, // R5, R3 -1
    '{2'b10, 32'd7,        32'd7,        16'h8000, 32'h40000, 32'h20000,    1'b0}, // R5, R3 min
    '{2'b00, 32'd1,        32'd1,        16'h0001, 32'h10,    32'h14,       1'b0}, // R9 none
    '{2'b01, 32'h80000000, 32'h0,        16'h7FFF, 32'h0,     32'h1FFFC,    1'b0}, // R4 msb
    '{2'b10, 32'h80000000, 32'h0,        16'h7FFF, 32'h0,     32'h1FFFC,    1'b1}, // R5 msb
    '{2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFE, 32'h4,     32'hFFFFFFFC, 1'b1}  // R3 wrap
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc_before;
    rst_n = 1'b0; stall = 1'b0; btype = 2'b00;
    rs = '0; rt = '0; off = '0; pc4 = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(pc == 32'h0, "R1 reset pc", pc, 32'h0);

    // R2: sequential stepping
    for (int i = 0; i < 3; i++) begin
      pc_before = pc;
      chk(pc_p4 == pc_before + 32'd4, "R2 pc_plus4", pc_p4, pc_before + 32'd4);
      @(negedge clk); #2;
      chk(pc == pc_before + 32'd4, "R2 advance", pc, pc_before + 32'd4);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      btype = VECS[i].ty; rs = VECS[i].a; rt = VECS[i].b;
      off = VECS[i].o; pc4 = VECS[i].p4;
      #2;
      pc_before = pc;
      chk(tgt == VECS[i].et, "R3 target", tgt, VECS[i].et);
      chk(taken == VECS[i].ek, "R4/R5/R9 taken", {31'd0, taken}, {31'd0, VECS[i].ek});
      chk(flush == VECS[i].ek, "R7 flush", {31'd0, flush}, {31'd0, VECS[i].ek});
      @(negedge clk); #2;
      if (VECS[i].ek)
        chk(pc == VECS[i].et, "R6 redirect", pc, VECS[i].et);
      else
        chk(pc == pc_before + 32'd4, "R6 sequential", pc, pc_before + 32'd4);
    end

    // R10: last vector left pc at 0xFFFFFFFC
    btype = 2'b00;
    #1;
    chk(pc == 32'hFFFFFFFC, "R10 pre-wrap pc", pc, 32'hFFFFFFFC);
    @(negedge clk); #2;
    chk(pc == 32'h0, "R10 wrap", pc, 32'h0);

    // R9: reserved encoding with equal operands
    btype = 2'b11; rs = 32'd9; rt = 32'd9; off = 16'h0010; pc4 = 32'h80;
    #1;
    chk(!taken && !flush, "R9 reserved", {30'd0, taken, flush}, 32'd0);
    pc_before = pc;
    @(negedge clk); #2;
    chk(pc == pc_before + 32'd4, "R9 no redirect", pc, pc_before + 32'd4);

    // R8: stall with a true condition
    btype = 2'b01; stall = 1'b1;
    #1;
    pc_before = pc;
    chk(!taken, "R8 taken blocked", {31'd0, taken}, 32'd0);
    chk(!flush, "R8 flush blocked", {31'd0, flush}, 32'd0);
    @(negedge clk); #2;
    chk(pc == pc_before, "R8 pc held", pc, pc_before);
    @(negedge clk); #2;
    chk(pc == pc_before, "R8 pc held 2", pc, pc_before);

    // release stall: branch resolves now (R6, R7)
    stall = 1'b0;
    #1;
    chk(flush, "R7 flush after stall", {31'd0, flush}, 32'd1);
    @(negedge clk); #2;
    chk(pc == 32'hC0, "R6 redirect after stall", pc, 32'hC0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule